// File: doc/BRIEF.md
# Two-Hot Threshold Leak Timer

This block is a free-running timer on the memory clock that emits a periodic single-cycle leak pulse. A consumer such as an error counter uses each pulse to drain one unit from a leaky bucket. The 53-bit count is made of an 11-bit prescaler, which only supplies carry strobes, and a 42-bit upper counter. The upper counter is itself a pair of words: a 32-bit lower word and a 10-bit upper word.

The leak period is set by two threshold words. Each word is a 42-bit one-hot vector that marks one bit of the upper counter. When both marked bits of the registered upper counter are set, the whole count restarts from zero and the leak pulse is raised in the next cycle. Software can overwrite the 10 most significant counter bits and can read them back through a 32-bit view.

The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. Every pin is a plain control or status level, sampled on each rising clock edge.

Top module: `leak_timer`

## Requirements
- R1: While `rst_i` is high at a clock edge, the prescaler and the upper counter become zero and `leak_o` becomes 0. `rd_view_o` therefore reads 0 after that edge.
- R2: With `en_i` high and no write and no match, the prescaler counts every cycle. The upper counter advances by one only when the prescaler rolls over from 2047 to 0, which is once every 2048 cycles.
- R3: `rd_view_o[9:0]` always shows upper counter bits 41:32, and `rd_view_o[31:10]` always reads 0.
- R4: A cycle with `sw_wr_i` high (and `en_i` high) loads `sw_data_i` into upper counter bits 41:32. In that cycle the prescaler and the lower 32 counter bits hold their values and no count occurs.
- R5: Suppose `thr_hi_i` has bit i set and `thr_lo_i` has bit j set. When the registered upper counter has both bit i and bit j set, `leak_o` is 1 for exactly one cycle, starting in the following cycle. With i=1 and j=0, consecutive pulses are 6145 cycles apart.
- R6: In the cycle where `leak_o` is 1, the full 53-bit count is zero, so `rd_view_o` reads 0.
- R7: If both threshold words mark the same bit, a match needs only that bit. With bit 0 selected, consecutive pulses are 2049 cycles apart.
- R8: If either threshold word is all zeros, no leak pulse is produced.
- R9: A cycle with `en_i` low clears the whole count and leaves `leak_o` at 0 afterwards.
- R10: If a write and a match fall in the same cycle, the write wins. No pulse is produced, and the next compare uses the written value.
- R11: The threshold inputs are sampled every cycle. A changed threshold is compared against the counter value held in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable; low clears the count |
| thr_hi_i | input | 42 | First threshold word, one-hot over the upper counter |
| thr_lo_i | input | 42 | Second threshold word, one-hot over the upper counter |
| sw_wr_i | input | 1 | Software write strobe for the top 10 counter bits |
| sw_data_i | input | 10 | Value written to counter bits 41:32 |
| leak_o | output | 1 | One-cycle leak pulse |
| rd_view_o | output | 32 | Read view: bits 9:0 are counter bits 41:32, other bits zero |

## Verification
A software write and a threshold match can fall in the same cycle. The write must suppress the pulse and replace the compared value.

The bench provokes this directly. It first loads the top bits so that a match is already present, then applies a new threshold and a write of a non-matching value together. It judges the outcome by requiring no pulse and the written value on the read view in that cycle and the next one.

The random phase mixes writes, enable drops and threshold changes against a cycle-level model. This model catches any other collision between load, clear and fire.

// File: rtl/leak_timer_pkg.sv
package leak_timer_pkg;
  // Action chosen for the count state each cycle, highest priority first.
  typedef enum logic [1:0] {
    ACT_CLEAR,
    ACT_LOAD,
    ACT_FIRE,
    ACT_COUNT
  } leak_act_e;
endpackage

// File: rtl/leak_prescaler.sv
module leak_prescaler #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LAST = '1;

  always_ff @(posedge clk_i) begin
    if (clr_i)      cnt_o <= '0;
    else if (adv_i) cnt_o <= cnt_o + 1'b1;
  end

  // Roll-over strobe that drives the upper counter.
  assign carry_o = adv_i && (cnt_o == LAST);
endmodule

// File: rtl/leak_upper_pair.sv
module leak_upper_pair #(
  parameter int UP_W = 42,
  parameter int HI_W = 10
) (
  input  logic            clk_i,
  input  logic            clr_i,
  input  logic            inc_i,
  input  logic            ld_i,
  input  logic [HI_W-1:0] ld_data_i,
  output logic [UP_W-1:0] cnt_o
);
  localparam int LO_W = UP_W - HI_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_wrap;

  // The lower word rolling over carries into the upper word.
  assign lo_wrap = inc_i && (&lo_q);

  always_ff @(posedge clk_i) begin
    if (clr_i)                lo_q <= '0;
    else if (inc_i && !ld_i)  lo_q <= lo_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (clr_i)                  hi_q <= '0;
    else if (ld_i)              hi_q <= ld_data_i;
    else if (lo_wrap)           hi_q <= hi_q + 1'b1;
  end

  assign cnt_o = {hi_q, lo_q};
endmodule

// File: rtl/leak_match.sv
module leak_match #(
  parameter int UP_W = 42
) (
  input  logic [UP_W-1:0] cnt_i,
  input  logic [UP_W-1:0] thr_a_i,
  input  logic [UP_W-1:0] thr_b_i,
  output logic            hit_o
);
  logic [UP_W-1:0] need;

  // Each marked bit is satisfied when it is set in the counter.
  // Bits that are not marked are satisfied automatically.
  for (genvar b = 0; b < UP_W; b++) begin : g_bit
    assign need[b] = !(thr_a_i[b] || thr_b_i[b]) || cnt_i[b];
  end

  // Both words must mark something; the same bit twice means a single-bit match.
  assign hit_o = (|thr_a_i) && (|thr_b_i) && (&need);
endmodule

// File: rtl/leak_timer.sv
module leak_timer
  import leak_timer_pkg::*;
#(
  parameter int PRE_W = 11,
  parameter int UP_W  = 42,
  parameter int RD_W  = 10,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [UP_W-1:0]  thr_hi_i,
  input  logic [UP_W-1:0]  thr_lo_i,
  input  logic             sw_wr_i,
  input  logic [RD_W-1:0]  sw_data_i,
  output logic             leak_o,
  output logic [REG_W-1:0] rd_view_o
);
  localparam int PAD_W = REG_W - RD_W;

  leak_act_e        act;
  logic             hit;
  logic             pre_carry;
  logic [PRE_W-1:0] pre_cnt;
  logic [UP_W-1:0]  up_cnt;
  logic             leak_q;

  leak_match #(.UP_W(UP_W)) u_match (
    .cnt_i   (up_cnt),
    .thr_a_i (thr_hi_i),
    .thr_b_i (thr_lo_i),
    .hit_o   (hit)
  );

  // Priority order: clear, then software load, then fire, then count.
  always_comb begin
    if (rst_i || !en_i) act = ACT_CLEAR;
    else if (sw_wr_i)   act = ACT_LOAD;
    else if (hit)       act = ACT_FIRE;
    else                act = ACT_COUNT;
  end

  leak_prescaler #(.W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .clr_i   (act == ACT_CLEAR || act == ACT_FIRE),
    .adv_i   (act == ACT_COUNT),
    .cnt_o   (pre_cnt),
    .carry_o (pre_carry)
  );

  leak_upper_pair #(.UP_W(UP_W), .HI_W(RD_W)) u_upper (
    .clk_i     (clk_i),
    .clr_i     (act == ACT_CLEAR || act == ACT_FIRE),
    .inc_i     (pre_carry),
    .ld_i      (act == ACT_LOAD),
    .ld_data_i (sw_data_i),
    .cnt_o     (up_cnt)
  );

  // The strobe is registered: it rises together with the cleared count.
  always_ff @(posedge clk_i) begin
    leak_q <= (act == ACT_FIRE);
  end

  assign leak_o    = leak_q;
  assign rd_view_o = {{PAD_W{1'b0}}, up_cnt[UP_W-1 -: RD_W]};

  // A rollover leaves the prescaler at zero and moves the upper counter by one.
  assert_carry_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    pre_carry |=> (pre_cnt == '0 && up_cnt == $past(up_cnt) + 1'b1));

  // Without a carry, a load, a clear or a fire, the upper counter stays put.
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (act == ACT_COUNT && !pre_carry) |=> $stable(up_cnt));

  // A pulse is a single cycle long.
  assert_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    leak_q |=> !leak_q);

  // A pulse coincides with a count of zero.
  assert_leak_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    leak_q |-> (up_cnt == '0 && pre_cnt == '0));

  // An empty threshold word never produces a pulse.
  assert_no_thr_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (thr_hi_i == '0 || thr_lo_i == '0) |=> !leak_q);

  // Dropping enable clears the count and keeps the strobe low.
  assert_disable_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!leak_q && up_cnt == '0 && pre_cnt == '0));

  // A write loads the top bits and suppresses any pulse in the same cycle.
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && sw_wr_i) |=> (!leak_q && up_cnt[UP_W-1 -: RD_W] == $past(sw_data_i)));
endmodule

// File: tb/leak_timer_tb.sv
module leak_timer_tb_top;
  localparam int UP_W = 42;

  logic            clk = 1'b0;
  logic            rst_i, en_i, sw_wr_i;
  logic [UP_W-1:0] thr_hi_i, thr_lo_i;
  logic [9:0]      sw_data_i;
  logic            leak_o;
  logic [31:0]     rd_view_o;

  always #4 clk = ~clk;

  leak_timer dut_i (
    .clk_i(clk), .rst_i(rst_i), .en_i(en_i),
    .thr_hi_i(thr_hi_i), .thr_lo_i(thr_lo_i),
    .sw_wr_i(sw_wr_i), .sw_data_i(sw_data_i),
    .leak_o(leak_o), .rd_view_o(rd_view_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [10:0]     m_pre;
  logic [UP_W-1:0] m_up;
  logic            m_leak;

  function automatic logic [UP_W-1:0] bit_at(input int n);
    return {{(UP_W-1){1'b0}}, 1'b1} << n;
  endfunction

  function automatic logic model_hit(input logic [UP_W-1:0] c,
                                     input logic [UP_W-1:0] a,
                                     input logic [UP_W-1:0] b);
    if (a == '0 || b == '0) return 1'b0;
    return ((c & (a | b)) == (a | b));
  endfunction

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: advance the model from the current inputs, then compare after the edge.
  task automatic tick();
    @(negedge clk);
    if (rst_i || !en_i) begin m_pre = '0; m_up = '0; m_leak = 1'b0; end
    else if (sw_wr_i) begin m_up[UP_W-1 -: 10] = sw_data_i; m_leak = 1'b0; end
    else if (model_hit(m_up, thr_hi_i, thr_lo_i)) begin m_pre = '0; m_up = '0; m_leak = 1'b1; end
    else begin
      m_leak = 1'b0;
      if (m_pre == 11'h7FF) m_up = m_up + 1'b1;
      m_pre = m_pre + 1'b1;
    end
    @(posedge clk); #1;
    cyc++;
    check(leak_o == m_leak, "R5 model leak", leak_o, m_leak);
    check(rd_view_o == {22'b0, m_up[UP_W-1 -: 10]}, "R3 model view", rd_view_o, m_up[UP_W-1 -: 10]);
  endtask

  task automatic write_top(input logic [9:0] d);
    sw_wr_i = 1'b1; sw_data_i = d;
    tick();
    sw_wr_i = 1'b0;
  endtask

  task automatic wait_leak(input int limit, output int at);
    at = -1;
    for (int k = 0; k < limit; k++) begin
      tick();
      if (leak_o) begin at = cyc; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int c0, a1, a2, gap_seen;
    logic seen;
    void'($urandom(32'd20240607));
    rst_i = 1'b1; en_i = 1'b1; sw_wr_i = 1'b0; sw_data_i = '0;
    thr_hi_i = bit_at(1); thr_lo_i = bit_at(0);
    m_pre = '0; m_up = '0; m_leak = 1'b0;
    tick(); tick();
    // R1: reset state
    check(leak_o == 1'b0 && rd_view_o == 32'h0, "R1 reset state", rd_view_o, 0);
    rst_i = 1'b0;

    // R5, R2: bits 1 and 0 give a 6145-cycle period
    c0 = cyc;
    wait_leak(7000, a1);
    check(a1 == c0 + 6145, "R2 first leak cycle", a1 - c0, 6145);
    check(rd_view_o == 32'h0, "R6 view zero at leak", rd_view_o, 0);
    tick();
    check(leak_o == 1'b0, "R5 pulse width one", leak_o, 0);
    wait_leak(7000, a2);
    check(a2 - a1 == 6145, "R5 leak period", a2 - a1, 6145);

    // R7: same bit on both words, period 2049
    thr_hi_i = bit_at(0); thr_lo_i = bit_at(0);
    en_i = 1'b0; tick(); en_i = 1'b1;
    wait_leak(3000, a1);
    wait_leak(3000, a2);
    check(a2 - a1 == 2049, "R7 single-bit period", a2 - a1, 2049);

    // R4: a write stalls the prescaler for one cycle
    repeat (100) tick();
    write_top(10'h000);
    wait_leak(3000, a2);
    check(a2 - a1 == 2049 + 2049 + 1, "R4 write holds prescaler", a2 - a1, 4099);

    // R5: match on the two top bits after a write
    thr_hi_i = bit_at(41); thr_lo_i = bit_at(32);
    write_top(10'h201);
    check(rd_view_o == 32'h201 && !leak_o, "R4 write loads top", rd_view_o, 32'h201);
    tick();
    check(leak_o == 1'b1 && rd_view_o == 0, "R5 leak after top match", leak_o, 1);

    // R10: write and match in the same cycle
    thr_lo_i = '0;
    write_top(10'h201);
    thr_lo_i = bit_at(32);
    write_top(10'h001);
    check(leak_o == 1'b0 && rd_view_o == 32'h001, "R10 write beats match", rd_view_o, 32'h001);
    tick();
    check(leak_o == 1'b0, "R10 compare uses written value", leak_o, 0);

    // R11: a new threshold applies on the next compare
    thr_hi_i = bit_at(32);
    tick();
    check(leak_o == 1'b1, "R11 threshold change", leak_o, 1);

    // R8: empty threshold word, all top bits set
    thr_hi_i = bit_at(32); thr_lo_i = '0;
    write_top(10'h3FF);
    seen = 1'b0;
    for (int k = 0; k < 3000; k++) begin tick(); if (leak_o) seen = 1'b1; end
    check(!seen && rd_view_o == 32'h3FF, "R8 no leak with empty word", seen, 0);

    // R9: enable low clears
    en_i = 1'b0; tick();
    check(!leak_o && rd_view_o == 0, "R9 disable clears", rd_view_o, 0);
    en_i = 1'b1;

    // Random phase against the model
    gap_seen = 0;
    for (int k = 0; k < 20000; k++) begin
      if (k % 400 == 0) begin
        int s;
        s = $urandom_range(0, 5);
        thr_hi_i = (s == 0) ? '0 : bit_at((s < 3) ? $urandom_range(0, 2) : $urandom_range(32, 41));
        thr_lo_i = bit_at((s == 5) ? $urandom_range(0, 1) : $urandom_range(32, 41));
      end
      sw_wr_i = ($urandom_range(0, 150) == 0);
      sw_data_i = 10'($urandom);
      en_i = ($urandom_range(0, 600) != 0);
      tick();
      if (leak_o) gap_seen++;
    end
    sw_wr_i = 1'b0; en_i = 1'b1;
    check(gap_seen > 0, "R5 random leaks occurred", gap_seen, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule